// File: doc/BRIEF.md
# Programmable Divider Enable Generator

This block divides a fast oscillator clock into short enable pulses for a time-to-digital converter that measures oscillator periods. The programmed ratio is the oscillator-to-reference frequency ratio. The divider runs at half that ratio, so it fires twice per reference period. Successive pulses therefore frame a free-running oscillator cycle and an injection-disturbed cycle in turn. The divider is a cascade of divide-by-2/3 cells, each stepped by the cell below it. Cells above the most significant set bit of the internal ratio are held idle. This allows any internal ratio from 2 upward without those cells toggling.

Pulse width comes from the cascade level selected as the tap. A higher tap gives a wider window, which suits a converter that needs a minimum measurement time. To line the pulses up with the injection cycle, a step command slips the divider phase by one fast-clock period. It does this by running a single divider cycle one count short or one count long. A one-cycle done flag marks the return to the nominal ratio. Ratio and tap are sampled only at the divider cycle boundary, so a change never produces a malformed cycle.

Top module: `mmd_enable_gen`

## Requirements
- R1: While rst_ni is low, en_o and step_done_o are 0. After release with default parameters, the first en_o rising edge comes no more than 32 clock edges later.
- R2: Rising edges of en_o are spaced R = div_i/2 clock cycles apart, with bit 0 of div_i ignored. A ratio of 64 gives a spacing of 32.
- R3: R can be any value from 2 to 2^(NSTG+1)-1 (63 by default). A div_i that halves to less than 2 is treated as R = 2. Cascade cells above the top set bit of R stay idle.
- R4: With tap t, where 1 <= t and R >= 2^(t+1), en_o stays high for 2^t + (R mod 2^t) cycles. With tap 0, or a tap too high for R, en_o stays high for exactly 1 cycle. The reset tap is 1, which gives a width of 2 at R = 32.
- R5: A change to div_i or tap_i takes effect only from the next divider cycle boundary. The cycle already in progress keeps its old length.
- R6: A rising edge on step_i makes exactly one divider cycle R-1 long (step_dir_i = 0, advance) or R+1 long (step_dir_i = 1, retard). That cycle is the first full cycle after the request. Later cycles are R long again.
- R7: A step_i held high causes only one step. A rising edge that arrives while a step is pending or in progress is ignored.
- R8: step_done_o is high for exactly one cycle, in the cycle after the boundary that ends the stepped cycle. That is the same cycle in which en_o rises when the tap is 0.
- R9: An advance at R = 2 or a retard at R = 2^(NSTG+1)-1 leaves the cycle length unchanged, but step_done_o still pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | NSTG+2 | Oscillator-to-reference ratio; the divider runs at half of it |
| tap_i | input | clog2(NSTG+1) | Cascade level whose window forms the pulse |
| step_i | input | 1 | Phase-step request, acted on at its rising edge |
| step_dir_i | input | 1 | Step direction: 0 = advance by one cycle, 1 = retard by one cycle |
| en_o | output | 1 | Measurement enable pulse |
| step_done_o | output | 1 | One-cycle flag when the ratio returns to nominal |

## Verification
Two events share the divider cycle boundary. The boundary that ends a stepped cycle both restores the nominal ratio and launches the next enable pulse. The boundary that starts a stepped cycle also reloads the ratio and tap from the inputs. With the tap at 0, the bench issues step requests in both directions and checks three things: the done flag lands in the exact cycle of the enable rise that closes the stepped cycle, the interval before that rise is one shorter or one longer than nominal, and the intervals around it are unchanged. Extra requests are sent while a step is pending, while it is in progress, and as one long held request. The bench then checks that exactly one done flag appears and exactly one interval moves.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  typedef enum logic {
    STEP_ADV = 1'b0,
    STEP_RET = 1'b1
  } step_dir_e;
endpackage

// File: rtl/mmd_stage.sv
module mmd_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic swallow_i,
  input  logic mod_i,
  output logic tick_o,
  output logic mod_o
);
  logic [1:0] cnt_q;
  logic [1:0] last;
  logic       at_last;

  // one extra count per full cycle when this bit of the ratio is set
  assign last    = (swallow_i & mod_i) ? 2'd2 : 2'd1;
  assign at_last = (cnt_q >= last);
  assign tick_o  = en_i & tick_i & at_last;
  assign mod_o   = en_i & mod_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= 2'd0;
    else if (!en_i)   cnt_q <= 2'd0;
    else if (tick_i)  cnt_q <= at_last ? 2'd0 : cnt_q + 2'd1;
  end
endmodule

// File: rtl/mmd_chain.sv
module mmd_chain #(
  parameter int NSTG = 5,
  localparam int RW = NSTG + 1,
  localparam int TW = $clog2(NSTG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  input  logic [TW-1:0] tap_i,
  output logic          pulse_o,
  output logic          bound_o
);
  logic [NSTG-1:0] stg_en, tick_in, tick_out, mod_in, mod_out, top_mask;

  assign tick_in[0] = 1'b1;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    assign stg_en[g] = |ratio_i[RW-1:g+1];

    if (g > 0) begin : g_tick
      assign tick_in[g] = tick_out[g-1];
    end

    if (g == NSTG - 1) begin : g_top
      assign mod_in[g]   = 1'b1;
      assign top_mask[g] = stg_en[g];
    end else begin : g_mid
      // disabled upper cells present a constant modulus request
      assign mod_in[g]   = stg_en[g+1] ? mod_out[g+1] : 1'b1;
      assign top_mask[g] = stg_en[g] & ~stg_en[g+1];
    end

    mmd_stage u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (stg_en[g]),
      .tick_i   (tick_in[g]),
      .swallow_i(ratio_i[g]),
      .mod_i    (mod_in[g]),
      .tick_o   (tick_out[g]),
      .mod_o    (mod_out[g])
    );
  end

  assign bound_o = |(tick_out & top_mask);

  always_comb begin
    pulse_o = mod_out[0];
    for (int j = 1; j < NSTG; j++) begin
      if (tap_i == TW'(j) && stg_en[j]) pulse_o = mod_in[j-1];
    end
  end
endmodule

// File: rtl/mmd_ctrl.sv
module mmd_ctrl #(
  parameter int NSTG    = 5,
  parameter int DEF_DIV = 64,
  parameter int DEF_TAP = 1,
  localparam int RW = NSTG + 1,
  localparam int DW = NSTG + 2,
  localparam int TW = $clog2(NSTG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] div_i,
  input  logic [TW-1:0] tap_i,
  input  logic          step_i,
  input  logic          step_dir_i,
  input  logic          bound_i,
  output logic [RW-1:0] ratio_o,
  output logic [RW-1:0] nom_o,
  output logic [TW-1:0] tap_o,
  output logic          act_o,
  output logic          pend_o,
  output logic          done_o
);
  import mmd_pkg::*;

  localparam logic [RW-1:0] RMIN = RW'(2);
  localparam logic [RW-1:0] RMAX = '1;

  logic [RW-1:0] half, nom_d, ratio_q;
  logic [TW-1:0] tap_q;
  logic          step_q, pend_q, act_q, done_q, rise;
  step_dir_e     dir_q;

  assign half  = RW'(div_i >> 1);
  assign nom_d = (half < RMIN) ? RMIN : half;
  assign rise  = step_i & ~step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RW'(DEF_DIV / 2);
      tap_q   <= TW'(DEF_TAP);
      step_q  <= 1'b0;
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      dir_q   <= STEP_ADV;
    end else begin
      step_q <= step_i;
      done_q <= 1'b0;
      if (rise && !pend_q && !act_q) begin
        pend_q <= 1'b1;
        dir_q  <= step_dir_e'(step_dir_i);
      end
      if (bound_i) begin
        ratio_q <= nom_d;
        tap_q   <= tap_i;
        if (pend_q) begin
          act_q  <= 1'b1;
          pend_q <= 1'b0;
        end else if (act_q) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ratio_o = ratio_q;
    if (act_q) begin
      if (dir_q == STEP_RET) begin
        if (ratio_q != RMAX) ratio_o = ratio_q + RW'(1);
      end else begin
        if (ratio_q != RMIN) ratio_o = ratio_q - RW'(1);
      end
    end
  end

  assign nom_o  = ratio_q;
  assign tap_o  = tap_q;
  assign act_o  = act_q;
  assign pend_o = pend_q;
  assign done_o = done_q;
endmodule

// File: rtl/mmd_enable_gen.sv
module mmd_enable_gen #(
  parameter int NSTG    = 5,
  parameter int DEF_DIV = 64,
  parameter int DEF_TAP = 1,
  localparam int RW = NSTG + 1,
  localparam int DW = NSTG + 2,
  localparam int TW = $clog2(NSTG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] div_i,
  input  logic [TW-1:0] tap_i,
  input  logic          step_i,
  input  logic          step_dir_i,
  output logic          en_o,
  output logic          step_done_o
);
  logic [RW-1:0] ratio_eff, ratio_nom;
  logic [TW-1:0] tap_q;
  logic          bound, pulse, step_act, step_pend, en_q;

  mmd_ctrl #(.NSTG(NSTG), .DEF_DIV(DEF_DIV), .DEF_TAP(DEF_TAP)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_i),
    .tap_i     (tap_i),
    .step_i    (step_i),
    .step_dir_i(step_dir_i),
    .bound_i   (bound),
    .ratio_o   (ratio_eff),
    .nom_o     (ratio_nom),
    .tap_o     (tap_q),
    .act_o     (step_act),
    .pend_o    (step_pend),
    .done_o    (step_done_o)
  );

  mmd_chain #(.NSTG(NSTG)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(ratio_eff),
    .tap_i  (tap_q),
    .pulse_o(pulse),
    .bound_o(bound)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= pulse;
  end

  assign en_o = en_q;
endmodule

// File: rtl/mmd_enable_gen_chk.sv
module mmd_enable_gen_chk #(
  parameter int NSTG = 5,
  localparam int RW = NSTG + 1,
  localparam int TW = $clog2(NSTG + 1),
  localparam int GLIM = (1 << RW) - 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_o,
  input logic          done_o,
  input logic          bound_i,
  input logic          act_i,
  input logic          pend_i,
  input logic [RW-1:0] nom_i,
  input logic [TW-1:0] tap_i
);
  logic [RW:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gap_q <= '0;
    else if (bound_i) gap_q <= '0;
    else              gap_q <= gap_q + (RW+1)'(1);
  end

  // R2 R3
  bound_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < (RW+1)'(GLIM));

  // R4
  tap0_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_i == '0 && en_o) |=> !en_o);

  // R5
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> ($stable(nom_i) && $stable(tap_i)));

  // R6
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !bound_i) |=> act_i);

  // R7
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> !act_i);

  // R7
  ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !bound_i) |=> !pend_i);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || $fell(act_i)) |-> (done_o && $fell(act_i)));
endmodule

bind mmd_enable_gen mmd_enable_gen_chk #(.NSTG(NSTG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_o   (en_o),
  .done_o (step_done_o),
  .bound_i(bound),
  .act_i  (step_act),
  .pend_i (step_pend),
  .nom_i  (ratio_nom),
  .tap_i  (tap_q)
);

// File: tb/mmd_enable_gen_bench.sv
`timescale 1ns/1ps
module mmd_enable_gen_bench;
  localparam int NSTG = 5;
  localparam int DW = NSTG + 2;
  localparam int TW = $clog2(NSTG + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] div = DW'(64);
  logic [TW-1:0] tap = TW'(1);
  logic step = 1'b0, sdir = 1'b0;
  logic en, done;

  int total = 0, bad = 0, cyc = 0, run = 0;
  logic en_d = 1'b0;
  int rq[$];
  int wq[$];
  int dq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mmd_enable_gen u_mmd_enable_gen (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .tap_i(tap),
    .step_i(step), .step_dir_i(sdir), .en_o(en), .step_done_o(done)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      en_d = 1'b0;
      run  = 0;
    end else begin
      if (en && !en_d) rq.push_back(cyc);
      if (!en && en_d) wq.push_back(run);
      run = en ? run + 1 : 0;
      if (done) dq.push_back(cyc);
      en_d = en;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic collect(int n);
    rq.delete(); wq.delete(); dq.delete();
    while (rq.size() < n) tick(1);
  endtask

  // R1
  task automatic t_reset();
    int rel;
    tick(3);
    chk(en == 1'b0, "R1 en in reset", int'(en), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    rel = cyc;
    while (rq.size() == 0) tick(1);
    chk(rq[0] - rel > 0 && rq[0] - rel <= 32, "R1 first pulse", rq[0] - rel, 32);
  endtask

  task automatic t_period(int d, int t, int exp_r, int exp_w, string tag);
    div = DW'(d);
    tap = TW'(t);
    collect(3);
    collect(4);
    for (int i = 1; i < 4; i++)
      chk(rq[i] - rq[i-1] == exp_r, {tag, " period"}, rq[i] - rq[i-1], exp_r);
    tick(exp_r);
    chk(wq.size() > 0 && wq[wq.size()-1] == exp_w, {tag, " width"},
        (wq.size() > 0) ? wq[wq.size()-1] : -1, exp_w);
  endtask

  // R5
  task automatic t_cfg();
    div = DW'(64);
    tap = TW'(0);
    collect(3);
    collect(1);
    tick(5);
    div = DW'(40);
    while (rq.size() < 3) tick(1);
    chk(rq[1] - rq[0] == 32, "R5 old cycle kept", rq[1] - rq[0], 32);
    chk(rq[2] - rq[1] == 20, "R5 new ratio", rq[2] - rq[1], 20);
  endtask

  // R6 R7 R8
  task automatic t_step(bit dir, int exp_s, string tag);
    int exp_i;
    div = DW'(64);
    tap = TW'(0);
    collect(3);
    collect(1);
    tick(2);
    sdir = dir;
    step = 1'b1; tick(1); step = 1'b0;
    tick(10);
    step = 1'b1; tick(1); step = 1'b0;   // while pending
    tick(30);
    step = 1'b1;                          // rises while active, then held
    while (rq.size() < 6) tick(1);
    tick(60);
    step = 1'b0;
    for (int i = 1; i < 6; i++) begin
      exp_i = (i == 2) ? exp_s : 32;
      chk(rq[i] - rq[i-1] == exp_i, {tag, " R6 R7 interval"}, rq[i] - rq[i-1], exp_i);
    end
    chk(dq.size() == 1, {tag, " R8 done count"}, dq.size(), 1);
    chk(dq.size() > 0 && dq[0] == rq[2], {tag, " R8 done cycle"},
        (dq.size() > 0) ? dq[0] : -1, rq[2]);
  endtask

  // R9
  task automatic t_sat(int d, bit dir, int exp_r, int n);
    div = DW'(d);
    tap = TW'(0);
    sdir = dir;
    collect(3);
    collect(1);
    step = 1'b1; tick(1); step = 1'b0;
    while (rq.size() < n) tick(1);
    tick(exp_r);
    for (int i = 1; i < n; i++)
      chk(rq[i] - rq[i-1] == exp_r, "R9 interval", rq[i] - rq[i-1], exp_r);
    chk(dq.size() == 1, "R9 done count", dq.size(), 1);
  endtask

  initial begin
    t_reset();
    t_period(64, 1, 32, 2, "R2 R4 default");
    t_period(65, 1, 32, 2, "R2 odd lsb");
    t_period(64, 2, 32, 4, "R4 tap2");
    t_period(90, 2, 45, 5, "R4 tap2 r45");
    t_period(64, 0, 32, 1, "R4 tap0");
    t_period(64, 5, 32, 1, "R4 tap high");
    t_period(126, 3, 63, 15, "R3 max");
    t_period(6, 1, 3, 1, "R3 r3");
    t_period(4, 0, 2, 1, "R3 r2");
    t_period(2, 0, 2, 1, "R3 clamp");
    t_period(0, 1, 2, 1, "R3 clamp zero");
    t_cfg();
    t_step(1'b0, 31, "adv");
    t_step(1'b1, 33, "ret");
    t_sat(4, 1'b0, 2, 8);
    t_sat(126, 1'b1, 63, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule